// File: doc/BRIEF.md
# Buck Converter Fault Supervisor

This block watches the fault comparators of a synchronous buck controller and decides how the power stage reacts. It receives a over-current trip, an under-voltage flag, two over-voltage flags (a lower threshold for use during start-up and a higher one for steady state) and a soft-start-done indication. From these it produces gate overrides for the high-side and low-side switches, a one-cycle soft-start restart request, a lock indication for each latching fault and the number of over-current hiccups used so far.

Each fault type has its own policy. Over-current shuts both switches off for a timed off-period and then requests a restart, up to a fixed budget of attempts, after which the controller locks off. Under-voltage must persist for a qualification window, then causes the same timed shutdown and restart with no limit. Over-voltage turns the low-side switch on and the high-side off to pull the output down. During start-up it releases as soon as the flag clears. After soft-start it locks. Every lock stays until the supply power-on reset (`rst_n`) is asserted again. The reset input must already be released in step with `clk`.

Top module: `buck_fault_supervisor`

## Requirements
- R1: While and after reset, all gate overrides, the restart request and both lock outputs are 0, and the hiccup count is 0.
- R2: In normal operation, an over-current trip with fewer than OC_MAX_HICCUP hiccups used forces both gates off (high-side off and low-side off asserted) from the next cycle for exactly HICCUP_OFF_CYC cycles, and increments the hiccup count by one.
- R3: When a hiccup off-period ends, all overrides release, and in that same first released cycle `ss_restart_o` is high for exactly one cycle.
- R4: An over-current trip in normal operation when the count already equals OC_MAX_HICCUP (default 4) sets `oc_lock_o` from the next cycle, with both gates held off, no restart request and the count held at OC_MAX_HICCUP.
- R5: Under-voltage acts only when `uv_flag_i` is sampled high on UV_QUAL_CYC consecutive clock edges while in normal operation with `ss_done_i` high. A shorter run, or a run with `ss_done_i` low, changes no output.
- R6: A qualified under-voltage fault starts a hiccup identical in timing to R2 and R3. It never locks and never changes the over-current hiccup count, however often it repeats.
- R7: With `ss_done_i` low, `ov_early_i` high forces high-side off and low-side on from the next cycle. One cycle after the flag clears, normal operation resumes without a lock or a restart request.
- R8: With `ss_done_i` high, `ov_early_i` alone is ignored. `ov_late_i` high sets `ov_lock_o` with high-side off and low-side on, held regardless of later inputs.
- R9: When an over-voltage condition and an over-current trip or qualified under-voltage happen on the same edge, the over-voltage response wins and the hiccup count is unchanged. This applies in normal operation and during a hiccup.
- R10: Once either lock is set, it and its gate overrides persist through any input changes, including further fault flags, until `rst_n` is asserted.
- R11: The low-side on and low-side off overrides are never both asserted, and the hiccup count never exceeds OC_MAX_HICCUP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low supply power-on reset, asynchronous assert |
| oc_trip_i | input | 1 | Over-current comparator trip |
| uv_flag_i | input | 1 | Feedback below under-voltage threshold (about 75% of reference) |
| ov_early_i | input | 1 | Feedback above start-up over-voltage threshold (about 137.5%) |
| ov_late_i | input | 1 | Feedback above steady-state over-voltage threshold (about 162.5%) |
| ss_done_i | input | 1 | Soft-start has completed |
| hs_force_off_o | output | 1 | Hold the high-side gate off |
| ls_force_off_o | output | 1 | Hold the low-side gate off |
| ls_force_on_o | output | 1 | Hold the low-side gate on |
| ss_restart_o | output | 1 | One-cycle request to restart soft-start |
| oc_lock_o | output | 1 | Over-current lock-off is active |
| ov_lock_o | output | 1 | Over-voltage lock is active |
| oc_hiccup_cnt_o | output | CNT_W | Over-current hiccups used since reset |

## Verification
The conflicts that matter are an over-voltage condition landing on the same edge as an over-current trip or as the final cycle of under-voltage qualification. The bench provokes these by raising the flags together in one drive cycle, both from normal operation and in the middle of a hiccup. A reference model in the bench applies the priority from the requirements. Its outputs are compared with the design every cycle, and named checks confirm that the low-side switch is driven on, not off, and that the hiccup count did not move.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_HIC_OC  = 3'd1,
    ST_HIC_UV  = 3'd2,
    ST_OV_SOFT = 3'd3,
    ST_OV_LOCK = 3'd4,
    ST_OC_LOCK = 3'd5
  } bfs_state_e;

  function automatic logic is_hiccup(input bfs_state_e s);
    return (s == ST_HIC_OC) || (s == ST_HIC_UV);
  endfunction

  function automatic logic is_locked(input bfs_state_e s);
    return (s == ST_OV_LOCK) || (s == ST_OC_LOCK);
  endfunction

endpackage

// File: rtl/bfs_uv_qual.sv
module bfs_uv_qual #(
  parameter int QUAL_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic qual_o
);

  generate
    if (QUAL_CYC <= 1) begin : g_direct
      assign qual_o = arm_i;
    end else begin : g_count
      localparam int CW = $clog2(QUAL_CYC);
      localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!arm_i)             cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign qual_o = arm_i && (cnt_q == LAST);

      // R5
      uv_streak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> $past(arm_i));
    end
  endgenerate

endmodule

// File: rtl/bfs_hiccup_timer.sv
module bfs_hiccup_timer #(
  parameter int OFF_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  generate
    if (OFF_CYC <= 1) begin : g_single
      assign done_o = run_i;
    end else begin : g_count
      localparam int CW = $clog2(OFF_CYC);
      localparam logic [CW-1:0] LAST = CW'(OFF_CYC - 1);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          at_last;

      assign at_last = (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (!run_i)       cnt_d = '0;
        else if (at_last) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign done_o = run_i && at_last;

      // R3
      off_single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    end
  endgenerate

endmodule

// File: rtl/bfs_oc_budget.sv
module bfs_oc_budget #(
  parameter int MAX_HIC = 4,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] MAXV = CW'(MAX_HIC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = take_i && (cnt_q != MAXV);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign full_o = (cnt_q == MAXV);
  assign cnt_o  = cnt_q;

  // R11
  budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= MAXV);

  // R2
  budget_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !full_o) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
  import bfs_pkg::*;
#(
  parameter int UV_QUAL_CYC    = 3000,
  parameter int HICCUP_OFF_CYC = 20000,
  parameter int OC_MAX_HICCUP  = 4,
  parameter int CNT_W          = $clog2(OC_MAX_HICCUP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oc_trip_i,
  input  logic             uv_flag_i,
  input  logic             ov_early_i,
  input  logic             ov_late_i,
  input  logic             ss_done_i,
  output logic             hs_force_off_o,
  output logic             ls_force_off_o,
  output logic             ls_force_on_o,
  output logic             ss_restart_o,
  output logic             oc_lock_o,
  output logic             ov_lock_o,
  output logic [CNT_W-1:0] oc_hiccup_cnt_o
);

  bfs_state_e state_q, state_d;
  logic       restart_q, restart_d;
  logic       uv_arm, uv_qual;
  logic       off_run, off_done;
  logic       take_oc, budget_full;
  logic       ov_lock_hit, ov_soft_hit;

  assign uv_arm  = (state_q == ST_RUN) && ss_done_i && uv_flag_i;
  assign off_run = is_hiccup(state_q);

  bfs_uv_qual #(.QUAL_CYC(UV_QUAL_CYC)) u_uv_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (uv_arm),
    .qual_o (uv_qual)
  );

  bfs_hiccup_timer #(.OFF_CYC(HICCUP_OFF_CYC)) u_off_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (off_run),
    .done_o (off_done)
  );

  bfs_oc_budget #(.MAX_HIC(OC_MAX_HICCUP), .CW(CNT_W)) u_oc_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take_oc),
    .full_o (budget_full),
    .cnt_o  (oc_hiccup_cnt_o)
  );

  assign ov_lock_hit = ss_done_i && ov_late_i;
  assign ov_soft_hit = !ss_done_i && ov_early_i;

  // Next-state: locks are terminal, over-voltage outranks everything else.
  always_comb begin
    state_d   = state_q;
    take_oc   = 1'b0;
    restart_d = 1'b0;
    if (is_locked(state_q)) begin
      state_d = state_q;
    end else if (ov_lock_hit) begin
      state_d = ST_OV_LOCK;
    end else if (ov_soft_hit) begin
      state_d = ST_OV_SOFT;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (oc_trip_i) begin
            if (budget_full) begin
              state_d = ST_OC_LOCK;
            end else begin
              state_d = ST_HIC_OC;
              take_oc = 1'b1;
            end
          end else if (uv_qual) begin
            state_d = ST_HIC_UV;
          end
        end
        ST_HIC_OC, ST_HIC_UV: begin
          if (off_done) begin
            state_d   = ST_RUN;
            restart_d = 1'b1;
          end
        end
        ST_OV_SOFT: state_d = ST_RUN;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
    end
  end

  // Output decode from registered state.
  always_comb begin
    hs_force_off_o = 1'b0;
    ls_force_off_o = 1'b0;
    ls_force_on_o  = 1'b0;
    case (state_q)
      ST_HIC_OC, ST_HIC_UV, ST_OC_LOCK: begin
        hs_force_off_o = 1'b1;
        ls_force_off_o = 1'b1;
      end
      ST_OV_SOFT, ST_OV_LOCK: begin
        hs_force_off_o = 1'b1;
        ls_force_on_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign ss_restart_o = restart_q;
  assign oc_lock_o    = (state_q == ST_OC_LOCK);
  assign ov_lock_o    = (state_q == ST_OV_LOCK);

  // R3
  restart_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart_o |-> (!hs_force_off_o && !ls_force_off_o && !ls_force_on_o));

  // R4
  oc_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_lock_o |=> (oc_lock_o && hs_force_off_o && ls_force_off_o && !ss_restart_o));

  // R8
  ov_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_lock_o |=> (ov_lock_o && ls_force_on_o && hs_force_off_o));

  // R9
  ov_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_lock_o && !ov_lock_o && ss_done_i && ov_late_i) |=> ov_lock_o);

  // R6
  uv_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIC_UV) |=> (!oc_lock_o && oc_hiccup_cnt_o == $past(oc_hiccup_cnt_o)));

  // R11
  low_side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_force_on_o && ls_force_off_o));

endmodule

// File: tb/buck_fault_supervisor_bench.sv
module buck_fault_supervisor_bench;

  localparam int UVQ  = 8;
  localparam int OFF  = 20;
  localparam int OCM  = 4;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_trip = 1'b0, uv_flag = 1'b0, ov_early = 1'b0, ov_late = 1'b0, ss_done = 1'b0;
  logic hs_off, ls_off, ls_on, restart, oc_lock, ov_lock;
  logic [CW-1:0] hic_cnt;

  always #2.5 clk = ~clk;

  buck_fault_supervisor #(
    .UV_QUAL_CYC(UVQ), .HICCUP_OFF_CYC(OFF), .OC_MAX_HICCUP(OCM), .CNT_W(CW)
  ) u_buck_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .oc_trip_i(oc_trip), .uv_flag_i(uv_flag),
    .ov_early_i(ov_early), .ov_late_i(ov_late), .ss_done_i(ss_done),
    .hs_force_off_o(hs_off), .ls_force_off_o(ls_off), .ls_force_on_o(ls_on),
    .ss_restart_o(restart), .oc_lock_o(oc_lock), .ov_lock_o(ov_lock),
    .oc_hiccup_cnt_o(hic_cnt)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 1'b0;
  string cur_req  = "R1";

  // Behavioural reference: mode 0 normal, 1 oc-hiccup, 2 uv-hiccup,
  // 3 soft over-voltage, 4 over-voltage lock, 5 over-current lock.
  int m_mode, m_used, m_streak, m_left;
  bit m_restart;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_used = 0; m_streak = 0; m_left = 0; m_restart = 0;
    end else begin
      m_restart = 0;
      if (m_mode == 0 && ss_done && uv_flag) m_streak++;
      else m_streak = 0;
      if (m_mode == 4 || m_mode == 5) begin
      end else if (ss_done && ov_late) m_mode = 4;
      else if (!ss_done && ov_early) m_mode = 3;
      else if (m_mode == 0) begin
        if (oc_trip) begin
          if (m_used == OCM) m_mode = 5;
          else begin m_used++; m_mode = 1; m_left = OFF; end
        end else if (m_streak >= UVQ) begin
          m_mode = 2; m_left = OFF;
        end
      end else if (m_mode == 1 || m_mode == 2) begin
        m_left--;
        if (m_left == 0) begin m_mode = 0; m_restart = 1; end
      end else if (m_mode == 3) m_mode = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cur_req, "hs_off", hs_off, m_mode != 0);
      chk(cur_req, "ls_off", ls_off, m_mode == 1 || m_mode == 2 || m_mode == 5);
      chk(cur_req, "ls_on",  ls_on,  m_mode == 3 || m_mode == 4);
      chk(cur_req, "restart", restart, m_restart);
      chk(cur_req, "oc_lock", oc_lock, m_mode == 5);
      chk(cur_req, "ov_lock", ov_lock, m_mode == 4);
      chk(cur_req, "count", hic_cnt, m_used);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_in();
    oc_trip = 0; uv_flag = 0; ov_early = 0; ov_late = 0;
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 0;
    tick(3);
    chk("R1", "hs_off in reset", hs_off, 0);
    chk("R10", "oc_lock in reset", oc_lock, 0);
    chk("R10", "ov_lock in reset", ov_lock, 0);
    rst_n = 1;
    tick(1);
  endtask

  task automatic oc_hiccup_round(input int exp_cnt);
    oc_trip = 1; tick(1); oc_trip = 0;
    chk("R2", "both gates off", hs_off & ls_off, 1);
    chk("R2", "count", hic_cnt, exp_cnt);
    tick(OFF - 1);
    chk("R2", "still off at end", ls_off, 1);
    chk("R3", "no early restart", restart, 0);
    tick(1);
    chk("R3", "restart pulse", restart, 1);
    chk("R3", "gates released", hs_off | ls_off | ls_on, 0);
    tick(1);
    chk("R3", "restart one cycle", restart, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    tick(2);
    chk("R1", "ls_on in reset", ls_on, 0);
    chk("R1", "restart in reset", restart, 0);
    chk("R1", "count in reset", hic_cnt, 0);
    rst_n = 1;
    tick(2);
    chk("R1", "idle overrides", hs_off | ls_off | ls_on, 0);

    // Over-current hiccups up to the budget, then lock.
    cur_req = "R2";
    ss_done = 1;
    for (int i = 1; i <= OCM; i++) oc_hiccup_round(i);
    cur_req = "R4";
    oc_trip = 1; tick(1); oc_trip = 0;
    chk("R4", "oc lock", oc_lock, 1);
    chk("R4", "count held", hic_cnt, OCM);
    tick(OFF + 5);
    chk("R4", "no restart while locked", restart, 0);
    cur_req = "R10";
    ov_late = 1; uv_flag = 1; tick(UVQ + 4); clear_in();
    chk("R10", "oc lock survives flags", oc_lock, 1);
    chk("R10", "ov not taken over lock", ov_lock, 0);
    do_reset();
    chk("R10", "lock cleared by reset", oc_lock, 0);

    // Under-voltage qualification.
    cur_req = "R5";
    ss_done = 1;
    uv_flag = 1; tick(UVQ - 1); uv_flag = 0; tick(1);
    chk("R5", "short uv ignored", hs_off, 0);
    ss_done = 0; uv_flag = 1; tick(UVQ + 3); uv_flag = 0; ss_done = 1; tick(1);
    chk("R5", "uv ignored before soft-start done", ls_off, 0);
    uv_flag = 1; tick(UVQ - 1);
    chk("R5", "not yet qualified", hs_off, 0);
    tick(1);
    chk("R5", "qualified uv acts", hs_off & ls_off, 1);
    cur_req = "R6";
    tick(6 * (OFF + UVQ));
    uv_flag = 0; tick(OFF + 2);
    chk("R6", "uv never locks", oc_lock, 0);
    chk("R6", "uv leaves count", hic_cnt, 0);
    chk("R6", "back to normal", hs_off | ls_off, 0);

    // OC during hiccup ignored.
    cur_req = "R2";
    oc_trip = 1; tick(1); tick(3);
    chk("R2", "oc during off-time no count", hic_cnt, 1);
    oc_trip = 0; tick(OFF);

    // Soft over-voltage during start-up.
    cur_req = "R7";
    ss_done = 0; ov_early = 1; tick(1);
    chk("R7", "low side on", ls_on & hs_off, 1);
    tick(4); ov_early = 0; tick(1);
    chk("R7", "releases", ls_on | hs_off, 0);
    chk("R7", "not latched", ov_lock, 0);
    chk("R7", "no restart", restart, 0);

    // Steady-state over-voltage.
    cur_req = "R8";
    ss_done = 1; ov_early = 1; tick(3);
    chk("R8", "early flag ignored after soft-start", ls_on, 0);
    ov_late = 1; tick(1); clear_in(); ss_done = 0; tick(5);
    chk("R8", "ov lock held", ov_lock & ls_on & hs_off, 1);
    do_reset();

    // Priority.
    cur_req = "R9";
    ss_done = 1; oc_trip = 1; uv_flag = 1; ov_late = 1; tick(1); clear_in();
    chk("R9", "ov wins", ov_lock, 1);
    chk("R9", "low side on", ls_on, 1);
    chk("R9", "count unchanged", hic_cnt, 0);
    do_reset();
    ss_done = 0; oc_trip = 1; ov_early = 1; tick(1); oc_trip = 0;
    chk("R9", "soft ov wins over oc", ls_on, 1);
    chk("R9", "count unchanged soft", hic_cnt, 0);
    ov_early = 0; tick(2);
    ss_done = 1; uv_flag = 1; tick(UVQ - 1); ov_late = 1; tick(1); clear_in();
    chk("R9", "ov beats uv qualification", ov_lock, 1);
    do_reset();
    ss_done = 1; oc_trip = 1; tick(1); oc_trip = 0; tick(5);
    ov_late = 1; tick(1); ov_late = 0;
    chk("R9", "ov beats hiccup", ov_lock, 1);
    cur_req = "R11";
    chk("R11", "low side exclusive", ls_on & ls_off, 0);
    do_reset();
    tick(3);
    finish_run();
  end

endmodule